// File: doc/BRIEF.md
# Programmable Almost-Flag Offset Unit

This block sits beside a FIFO's pointer logic and produces the two early-warning flags: almost-empty and almost-full. It holds one offset per flag. The almost-empty offset is measured up from an empty FIFO, and the almost-full offset is measured down from a full FIFO. Each cycle the block compares the FIFO's current word count against both thresholds and registers the results.

The level on `ld_sel` while `rst` is high picks the programming method. It also picks the default value that both offsets take. After reset, software can change the offsets in one of two ways:
- Serial method: bits are shifted in one at a time on `ser_bit`.
- Parallel method: whole words are taken from `din`.

In either method, the offsets can be read back in parallel on `dout`. The same `ld_sel` pin must be high for any load or readback to happen. A partial reset (`part_rst`) brings both access sequences back to their start. It keeps the programmed offsets and the chosen method.

Top module: `almost_flag_unit`

## Requirements
- R1: While `rst` is high, `ld_sel`=0 selects the parallel method and sets both offsets to DEF_PAR (127). `ld_sel`=1 selects the serial method and sets both offsets to DEF_SER (1023).
- R2: In the cycle after a reset edge, `ae_flag`=1, `af_flag`=0 and `dout`=0.
- R3: `ae_flag` is registered. It goes to 1 one cycle after a clock edge at which `count` is less than or equal to the almost-empty offset, and to 0 otherwise.
- R4: `af_flag` is registered. It goes to 1 one cycle after a clock edge at which `count` is greater than or equal to 2^ADDR_W minus the almost-full offset, and to 0 otherwise.
- R5: In the parallel method, each edge with `wr_en`=1 and `ld_sel`=1 stores `din[ADDR_W-1:0]` into one offset. The stores alternate: almost-empty first, then almost-full.
- R6: In the serial method, each edge with `ser_en`=1 and `ld_sel`=1 stores `ser_bit` into one offset bit. The order is bit 0 upward of the almost-empty offset, then bit 0 upward of the almost-full offset. After 2*ADDR_W bits the position returns to almost-empty bit 0.
- R7: Loading is ignored in these cases, and both offsets stay unchanged: `ld_sel`=0; `ser_en` in the parallel method; `wr_en` in the serial method.
- R8: Each edge with `rd_en`=1 and `ld_sel`=1 places an offset, zero-extended, on `dout` in the next cycle. The reads alternate: almost-empty first, then almost-full. This works in either method. Otherwise `dout` holds its value.
- R9: `part_rst`=1 keeps both offsets and the method. It returns the write alternation, the read alternation and the serial bit position to their start. No load or readback takes place in that cycle.
- R10: The write alternation and the read alternation advance independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, synchronous, active high |
| part_rst | input | 1 | Partial reset, synchronous, active high |
| ld_sel | input | 1 | Method select while in reset; gates every offset access afterwards |
| ser_en | input | 1 | Serial load enable |
| ser_bit | input | 1 | Serial load data bit |
| wr_en | input | 1 | Parallel load enable |
| rd_en | input | 1 | Parallel readback enable |
| din | input | DATA_W | Parallel load data |
| count | input | ADDR_W+1 | Current FIFO word count, 0 to 2^ADDR_W |
| ae_flag | output | 1 | Almost-empty flag |
| af_flag | output | 1 | Almost-full flag |
| dout | output | DATA_W | Offset readback |

## Verification
The count is driven through values just below, at and just above each threshold. This is done under the reset defaults of both methods and again under programmed offsets, so that an off-by-one comparison or a swapped threshold shows up.

Parallel writes are interleaved with readbacks, which separates the two alternation toggles. Serial streams longer than 2*ADDR_W bits expose errors in bit order and in the wrap point.

Enables are also applied in the wrong method and with `ld_sel` low, and each is followed by a readback, so that an ignored access is shown to leave both offsets untouched. A partial reset is placed in the middle of a sequence to check that the offsets are kept and the toggles are rewound.

// File: rtl/afu_pkg.sv
package afu_pkg;
  typedef enum logic {
    LOAD_PAR = 1'b0,
    LOAD_SER = 1'b1
  } load_mode_e;
endpackage

// File: rtl/afu_offset_store.sv
module afu_offset_store
  import afu_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 16,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              part_rst,
  input  logic              ld_sel,
  input  logic              ser_en,
  input  logic              ser_bit,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] din,
  output logic [ADDR_W-1:0] ae_off,
  output logic [ADDR_W-1:0] af_off,
  output load_mode_e        mode
);
  localparam int NBITS = 2 * ADDR_W;
  localparam int BPW   = $clog2(NBITS);
  localparam logic [ADDR_W-1:0] DEF_P = ADDR_W'(DEF_PAR);
  localparam logic [ADDR_W-1:0] DEF_S = ADDR_W'(DEF_SER);
  localparam logic [BPW-1:0]    BP_LAST = BPW'(NBITS - 1);

  logic [ADDR_W-1:0] ae_q, af_q, ae_ser, af_ser;
  logic [BPW-1:0]    bp_q;
  logic              wt_q;
  load_mode_e        mode_q;
  logic              do_ser, do_par;

  assign do_ser = ld_sel && ser_en && (mode_q == LOAD_SER);
  assign do_par = ld_sel && wr_en && (mode_q == LOAD_PAR);

  // serial bit insertion: one position per register bit
  always_comb begin
    ae_ser = ae_q;
    af_ser = af_q;
    for (int i = 0; i < ADDR_W; i++) begin
      if (bp_q == BPW'(i))          ae_ser[i] = ser_bit;
      if (bp_q == BPW'(i + ADDR_W)) af_ser[i] = ser_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= ld_sel ? LOAD_SER : LOAD_PAR;
      ae_q   <= ld_sel ? DEF_S : DEF_P;
      af_q   <= ld_sel ? DEF_S : DEF_P;
      bp_q   <= '0;
      wt_q   <= 1'b0;
    end else if (part_rst) begin
      bp_q <= '0;
      wt_q <= 1'b0;
    end else begin
      if (do_ser) begin
        ae_q <= ae_ser;
        af_q <= af_ser;
        bp_q <= (bp_q == BP_LAST) ? '0 : bp_q + 1'b1;
      end
      if (do_par) begin
        if (!wt_q) ae_q <= din[ADDR_W-1:0];
        else       af_q <= din[ADDR_W-1:0];
        wt_q <= ~wt_q;
      end
    end
  end

  assign ae_off = ae_q;
  assign af_off = af_q;
  assign mode   = mode_q;
endmodule

// File: rtl/afu_readback.sv
module afu_readback #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              part_rst,
  input  logic              ld_sel,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] ae_off,
  input  logic [ADDR_W-1:0] af_off,
  output logic [DATA_W-1:0] dout
);
  logic              rt_q;
  logic [DATA_W-1:0] dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rt_q   <= 1'b0;
      dout_q <= '0;
    end else if (part_rst) begin
      rt_q <= 1'b0;
    end else if (ld_sel && rd_en) begin
      dout_q <= rt_q ? DATA_W'(af_off) : DATA_W'(ae_off);
      rt_q   <= ~rt_q;
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/afu_flag_cmp.sv
module afu_flag_cmp #(
  parameter int ADDR_W  = 12,
  parameter bit IS_FULL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W:0]   count,
  input  logic [ADDR_W-1:0] offset,
  output logic              flag
);
  localparam logic [ADDR_W:0] DEPTH = (ADDR_W+1)'(1) << ADDR_W;

  logic hit;
  logic flag_q;

  generate
    if (IS_FULL) begin : g_full
      assign hit = count >= (DEPTH - {1'b0, offset});
    end else begin : g_empty
      assign hit = count <= {1'b0, offset};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) flag_q <= ~IS_FULL;
    else     flag_q <= hit;
  end

  assign flag = flag_q;
endmodule

// File: rtl/almost_flag_unit.sv
module almost_flag_unit
  import afu_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 16,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              part_rst,
  input  logic              ld_sel,
  input  logic              ser_en,
  input  logic              ser_bit,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W:0]   count,
  output logic              ae_flag,
  output logic              af_flag,
  output logic [DATA_W-1:0] dout
);
  logic [ADDR_W-1:0] ae_off_w, af_off_w;
  load_mode_e        mode_w;

  afu_offset_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEF_PAR(DEF_PAR), .DEF_SER(DEF_SER)
  ) u_store (
    .clk(clk), .rst(rst), .part_rst(part_rst), .ld_sel(ld_sel),
    .ser_en(ser_en), .ser_bit(ser_bit), .wr_en(wr_en), .din(din),
    .ae_off(ae_off_w), .af_off(af_off_w), .mode(mode_w)
  );

  afu_readback #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rb (
    .clk(clk), .rst(rst), .part_rst(part_rst), .ld_sel(ld_sel), .rd_en(rd_en),
    .ae_off(ae_off_w), .af_off(af_off_w), .dout(dout)
  );

  afu_flag_cmp #(.ADDR_W(ADDR_W), .IS_FULL(1'b0)) u_ae (
    .clk(clk), .rst(rst), .count(count), .offset(ae_off_w), .flag(ae_flag)
  );

  afu_flag_cmp #(.ADDR_W(ADDR_W), .IS_FULL(1'b1)) u_af (
    .clk(clk), .rst(rst), .count(count), .offset(af_off_w), .flag(af_flag)
  );
endmodule

// File: rtl/almost_flag_chk.sv
module almost_flag_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              part_rst,
  input logic              ld_sel,
  input logic              rd_en,
  input logic [ADDR_W:0]   count,
  input logic              ae_flag,
  input logic              af_flag,
  input logic [DATA_W-1:0] dout,
  input logic [ADDR_W-1:0] ae_off,
  input logic [ADDR_W-1:0] af_off
);
  localparam logic [ADDR_W:0] DEPTH = (ADDR_W+1)'(1) << ADDR_W;

  a_r3_empty_count_sets_ae: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |=> ae_flag);

  a_r4_full_count_sets_af: assert property (@(posedge clk) disable iff (rst)
    (count == DEPTH) |=> af_flag);

  a_r7_no_load_without_ld: assert property (@(posedge clk) disable iff (rst)
    !ld_sel |=> ($stable(ae_off) && $stable(af_off)));

  a_r9_prs_keeps_offsets: assert property (@(posedge clk) disable iff (rst)
    part_rst |=> ($stable(ae_off) && $stable(af_off)));

  a_r8_dout_holds: assert property (@(posedge clk) disable iff (rst)
    !(ld_sel && rd_en) |=> $stable(dout));

  a_r8_dout_is_offset: assert property (@(posedge clk) disable iff (rst)
    (ld_sel && rd_en && !part_rst) |=>
      ((dout == DATA_W'($past(ae_off))) || (dout == DATA_W'($past(af_off)))));
endmodule

bind almost_flag_unit almost_flag_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .part_rst(part_rst), .ld_sel(ld_sel), .rd_en(rd_en),
  .count(count), .ae_flag(ae_flag), .af_flag(af_flag), .dout(dout),
  .ae_off(ae_off_w), .af_off(af_off_w)
);

// File: tb/sim_almost_flag_unit.sv
module sim_almost_flag_unit;
  localparam int CLK_P  = 10;
  localparam int AW     = 10;
  localparam int DW     = 12;
  localparam int DEPTH  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1, part_rst = 1'b0, ld_sel = 1'b0;
  logic ser_en = 1'b0, ser_bit = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] din = '0;
  logic [AW:0]   count = '0;
  logic ae_flag, af_flag;
  logic [DW-1:0] dout;

  int vectors = 0, miscompares = 0;

  // reference model state
  bit m_ser;
  int m_ae, m_af, m_bp, m_dout;
  bit m_wt, m_rt, m_fae, m_faf;

  always #(CLK_P/2) clk = ~clk;

  almost_flag_unit #(.ADDR_W(AW), .DATA_W(DW), .DEF_PAR(127), .DEF_SER(1023)) u0 (
    .clk(clk), .rst(rst), .part_rst(part_rst), .ld_sel(ld_sel),
    .ser_en(ser_en), .ser_bit(ser_bit), .wr_en(wr_en), .rd_en(rd_en),
    .din(din), .count(count), .ae_flag(ae_flag), .af_flag(af_flag), .dout(dout)
  );

  task automatic cmp(input string tag, input int act, input int exp, input string what);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    if (rst) begin
      m_ser = ld_sel;
      m_ae = ld_sel ? 1023 : 127;
      m_af = m_ae;
      m_bp = 0; m_wt = 0; m_rt = 0; m_dout = 0;
      m_fae = 1; m_faf = 0;
    end else begin
      m_fae = int'(count) <= m_ae;
      m_faf = int'(count) >= DEPTH - m_af;
      if (part_rst) begin
        m_bp = 0; m_wt = 0; m_rt = 0;
      end else begin
        if (ld_sel && rd_en) begin
          m_dout = m_rt ? m_af : m_ae;
          m_rt = !m_rt;
        end
        if (ld_sel && ser_en && m_ser) begin
          if (m_bp < AW) m_ae[m_bp] = ser_bit;
          else           m_af[m_bp - AW] = ser_bit;
          m_bp = (m_bp == 2*AW - 1) ? 0 : m_bp + 1;
        end
        if (ld_sel && wr_en && !m_ser) begin
          if (!m_wt) m_ae = int'(din[AW-1:0]);
          else       m_af = int'(din[AW-1:0]);
          m_wt = !m_wt;
        end
      end
    end
    @(negedge clk);
    vectors++;
    cmp(tag, int'(ae_flag), int'(m_fae), "ae_flag");
    cmp(tag, int'(af_flag), int'(m_faf), "af_flag");
    cmp(tag, int'(dout), m_dout, "dout");
  endtask

  task automatic idle();
    part_rst = 0; ser_en = 0; wr_en = 0; rd_en = 0;
  endtask

  task automatic do_reset(input bit sel);
    idle(); rst = 1; ld_sel = sel; count = '0;
    step("R1"); step("R2");
    rst = 0; ld_sel = 0;
    step("R2");
  endtask

  task automatic pwrite(input int v, input string tag);
    idle(); ld_sel = 1; wr_en = 1; din = DW'(v); step(tag); idle(); ld_sel = 0;
  endtask

  task automatic pread(input string tag);
    idle(); ld_sel = 1; rd_en = 1; step(tag); idle(); ld_sel = 0;
  endtask

  task automatic sshift(input bit b, input string tag);
    idle(); ld_sel = 1; ser_en = 1; ser_bit = b; step(tag); idle(); ld_sel = 0;
  endtask

  task automatic put_count(input int c, input string tag);
    count = (AW+1)'(c); step(tag);
  endtask

  initial begin
    #(CLK_P * 100000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    // parallel method, defaults 127
    do_reset(1'b0);
    put_count(126, "R3"); put_count(127, "R3"); put_count(128, "R3");
    put_count(DEPTH - 128, "R4"); put_count(DEPTH - 127, "R4");
    put_count(DEPTH, "R4");
    pread("R1"); pread("R1");
    // R5 and R10: writes interleaved with reads
    pwrite(5, "R5"); pread("R10"); pread("R10");
    pwrite(24, "R5"); pread("R10"); pread("R10");
    put_count(5, "R3"); put_count(6, "R3");
    put_count(DEPTH - 25, "R4"); put_count(DEPTH - 24, "R4");
    // R7: serial enable ignored in parallel method, no-ld writes ignored
    sshift(1'b1, "R7"); sshift(1'b1, "R7");
    idle(); wr_en = 1; din = 12'h3AA; step("R7"); idle();
    idle(); rd_en = 1; step("R8"); idle();
    pread("R7"); pread("R7");
    // R9: partial reset mid-sequence
    pwrite(300, "R9");
    idle(); part_rst = 1; ld_sel = 1; wr_en = 1; rd_en = 1; din = 12'h011; step("R9");
    idle(); ld_sel = 0;
    pwrite(9, "R9"); pread("R9"); pread("R9");
    put_count(9, "R3"); put_count(10, "R3");
    // serial method, defaults 1023
    do_reset(1'b1);
    put_count(0, "R4"); put_count(1, "R4"); put_count(1023, "R3"); put_count(1024, "R3");
    pwrite(3, "R7"); pread("R1"); pread("R1");
    for (int i = 0; i < 2*AW; i++) sshift(((i * 7) % 3) == 1, "R6");
    pread("R6"); pread("R6");
    for (int i = 0; i < 5; i++) sshift(i[0], "R6");
    pread("R6"); pread("R6");
    idle(); part_rst = 1; step("R9"); idle();
    for (int i = 0; i < 3; i++) sshift(1'b1, "R9");
    pread("R9"); pread("R9");
    put_count(4, "R3"); put_count(DEPTH - 200, "R4"); put_count(DEPTH, "R4");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule